// File: doc/BRIEF.md
# Suspend-to-RAM Entry Sequencer

This block walks a memory and bus controller from normal operation into a suspend-to-RAM state and back. A suspend request first makes it ask the PCI bus unit for a stop-grant special cycle. Once the clock-stop request arrives, it gates off the internal clocks. When the system reset input asserts, the DDR output clocks run for a fixed number of memory-clock cycles so that registered DIMMs, whose reset shares that input, see a running clock while their reset goes active. After that window the block closes the DDR clock enable, isolates the I/O pads and closes the input clock gates. It also clears the two suspend status bits of its mode/status register and leaves every other bit of that register unchanged.

When the system reset input releases while power is good, the block reopens the chip in a fixed order: pad isolation goes first, then the input clocks, then the internal clocks. It then returns to idle. The DRAM clock-enable level stays low in every state except idle. In idle it follows the request from the memory logic. All clock-gate enables are registered on the falling edge of the clock, so the gated clocks cannot glitch.

Top module: `str_entry_seq`

## Requirements
- R1: After `rst_n` is released, the block is idle. `stop_grant_req` and `pad_iso` are 0, `core_clk_en`, `in_clk_en` and `ddr_clk_en` are 1, and `cfg_q` is 0.
- R2: When `susp_req` is sampled high in idle, `stop_grant_req` is 1 after the next rising edge. It stays 1 until `clk_stop_req` is sampled high.
- R3: When `clk_stop_req` is sampled high while the stop-grant request is pending, `stop_grant_req` drops at that rising edge. `core_clk_en` drops at the falling edge that follows that rising edge, and not before.
- R4: Call the rising edge that first samples `sys_reset` high after the clock stop edge 0. `ddr_clk_en` stays 1 through edges 0 to 5 and drops after edge 6, with `HOLD_CYCLES` = 6.
- R5: At edge 6, `pad_iso` becomes 1 and `in_clk_en` becomes 0. Both keep these values while `sys_reset` is high or `pwr_good` is low.
- R6: `cke` is 0 in every state other than idle. In idle it equals `mem_cke_req`.
- R7: At edge 6, bits [1:0] of `cfg_q` (the suspend status bits) are cleared to 0. Bits [7:2] keep their values. Writes with `cfg_we` load all of `cfg_q` from `cfg_wdata`.
- R8: Call the rising edge that samples `sys_reset` low with `pwr_good` high, while the pads are isolated, edge A. At edge A, `pad_iso` drops while `in_clk_en` and `core_clk_en` stay 0. After edge A+1, `in_clk_en` rises. After edge A+2, `core_clk_en` rises and the block is idle again.
- R9: `susp_req` has no effect in any state other than idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| susp_req | input | 1 | Suspend-to-RAM request |
| clk_stop_req | input | 1 | Clock-stop request |
| sys_reset | input | 1 | System reset input, active high |
| pwr_good | input | 1 | Power is stable |
| mem_cke_req | input | 1 | CKE level requested by the memory logic |
| cfg_we | input | 1 | Mode/status register write strobe |
| cfg_wdata | input | 8 | Mode/status register write data |
| stop_grant_req | output | 1 | Stop-grant special cycle request to the PCI unit |
| core_clk_en | output | 1 | Internal clock gate enable |
| ddr_clk_en | output | 1 | DDR output clock enable |
| cke | output | 1 | DRAM CKE level |
| pad_iso | output | 1 | I/O pad isolation enable |
| in_clk_en | output | 1 | Input clock gate enable (system, AGP and PCI) |
| cfg_q | output | 8 | Mode/status register contents |

## Verification
State and register outputs change at the rising edge that samples a stimulus. The clock-gate enables follow half a cycle later, at the next falling edge. The bench therefore drives inputs and samples every output 4 ns after a rising edge, which is after the falling edge, so both kinds of output show the result of that same rising edge. For R3 one extra sample 1 ns after the rising edge confirms that `core_clk_en` has not yet moved. The DDR window is counted edge by edge: six samples must show the enable high, and the seventh must show it low.

// File: rtl/str_entry_seq.sv
module str_entry_seq #(
  parameter int HOLD_CYCLES = 6,
  parameter int CFG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             susp_req,
  input  logic             clk_stop_req,
  input  logic             sys_reset,
  input  logic             pwr_good,
  input  logic             mem_cke_req,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             stop_grant_req,
  output logic             core_clk_en,
  output logic             ddr_clk_en,
  output logic             cke,
  output logic             pad_iso,
  output logic             in_clk_en,
  output logic [CFG_W-1:0] cfg_q
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
  localparam logic [CFG_W-1:0] STS_MASK = CFG_W'(3);

  typedef enum logic [5:0] {
    S_IDLE  = 6'b000001,
    S_SG    = 6'b000010,
    S_CSTOP = 6'b000100,
    S_HOLD  = 6'b001000,
    S_ISO   = 6'b010000,
    S_RES   = 6'b100000
  } state_t;

  state_t        st, st_nx;
  logic [CW-1:0] cnt;
  logic          enter_iso;

  assign enter_iso = (st == S_HOLD) && (cnt == LAST);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (susp_req)                st_nx = S_SG;
      S_SG:    if (clk_stop_req)            st_nx = S_CSTOP;
      S_CSTOP: if (sys_reset)               st_nx = S_HOLD;
      S_HOLD:  if (cnt == LAST)             st_nx = S_ISO;
      S_ISO:   if (!sys_reset && pwr_good)  st_nx = S_RES;
      S_RES:   if (cnt == CW'(1))           st_nx = S_IDLE;
      default:                              st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (st != st_nx)                     cnt <= enter_iso ? CW'(HOLD_CYCLES) : '0;
      else if (st == S_HOLD || st == S_RES) cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= '0;
    else if (enter_iso) cfg_q <= cfg_q & ~STS_MASK;
    else if (cfg_we)    cfg_q <= cfg_wdata;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_clk_en <= 1'b1;
      in_clk_en   <= 1'b1;
      ddr_clk_en  <= 1'b1;
    end else begin
      core_clk_en <= (st == S_IDLE) || (st == S_SG);
      in_clk_en   <= (st != S_ISO) && !((st == S_RES) && (cnt == '0));
      ddr_clk_en  <= (st != S_ISO);
    end
  end

  assign stop_grant_req = (st == S_SG);
  assign pad_iso        = (st == S_ISO);
  assign cke            = (st == S_IDLE) && mem_cke_req;

  p_sg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_grant_req && !clk_stop_req) |=> stop_grant_req);

  p_iso_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pad_iso |-> (!in_clk_en && !ddr_clk_en && !core_clk_en));

  p_cke_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_iso || stop_grant_req) |-> !cke);

  p_sts_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_iso) |-> (cfg_q[1:0] == 2'b00 && cfg_q[CFG_W-1:2] == $past(cfg_q[CFG_W-1:2])));

  p_release_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_iso) |-> (!in_clk_en && !core_clk_en));

  p_in_before_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> in_clk_en);
endmodule

// File: tb/str_entry_seq_tb.sv
module str_entry_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic susp_req = 0, clk_stop_req = 0, sys_reset = 0, pwr_good = 1, mem_cke_req = 0, cfg_we = 0;
  logic [7:0] cfg_wdata = '0;
  logic stop_grant_req, core_clk_en, ddr_clk_en, cke, pad_iso, in_clk_en;
  logic [7:0] cfg_q;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  str_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .susp_req(susp_req), .clk_stop_req(clk_stop_req),
    .sys_reset(sys_reset), .pwr_good(pwr_good), .mem_cke_req(mem_cke_req),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .stop_grant_req(stop_grant_req),
    .core_clk_en(core_clk_en), .ddr_clk_en(ddr_clk_en), .cke(cke),
    .pad_iso(pad_iso), .in_clk_en(in_clk_en), .cfg_q(cfg_q)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #4;
  endtask

  task automatic t_reset();
    rst_n = 0; tick(); rst_n = 1; tick();
    chk("R1 stop_grant", stop_grant_req, 0);
    chk("R1 pad_iso", pad_iso, 0);
    chk("R1 enables", {core_clk_en, in_clk_en, ddr_clk_en}, 3'b111);
    chk("R1 cfg", cfg_q, 0);
  endtask

  task automatic t_cfg_cke();
    cfg_we = 1; cfg_wdata = 8'hA7; tick(); cfg_we = 0;
    chk("R7 write", cfg_q, 8'hA7);
    mem_cke_req = 1; #0.1;
    chk("R6 idle cke follows", cke, 1);
  endtask

  task automatic t_entry();
    susp_req = 1; tick(); susp_req = 0;
    chk("R2 sg raised", stop_grant_req, 1);
    chk("R6 cke low in sg", cke, 0);
    tick();
    chk("R2 sg held", stop_grant_req, 1);
    clk_stop_req = 1;
    @(posedge clk); #1;
    chk("R3 sg drop", stop_grant_req, 0);
    chk("R3 core still on before fall", core_clk_en, 1);
    #3;
    chk("R3 core gated", core_clk_en, 0);
    clk_stop_req = 0;
    susp_req = 1; tick(); susp_req = 0;
    chk("R9 susp ignored sg", stop_grant_req, 0);
    chk("R9 susp ignored core", core_clk_en, 0);
    sys_reset = 1; pwr_good = 0; tick();
    chk("R4 ddr edge0", ddr_clk_en, 1);
    for (int i = 1; i <= 5; i++) begin
      tick();
      chk("R4 ddr during hold", ddr_clk_en, 1);
      chk("R5 no iso during hold", pad_iso, 0);
    end
    tick();
    chk("R4 ddr off edge6", ddr_clk_en, 0);
    chk("R5 pad iso", pad_iso, 1);
    chk("R5 in clk off", in_clk_en, 0);
    chk("R7 status cleared", cfg_q, 8'hA4);
    chk("R6 cke low iso", cke, 0);
  endtask

  task automatic t_resume();
    susp_req = 1; sys_reset = 0; tick(); susp_req = 0;
    chk("R5 stay iso no pwr", pad_iso, 1);
    chk("R9 susp ignored iso", stop_grant_req, 0);
    pwr_good = 1; tick();
    chk("R8 pad released", pad_iso, 0);
    chk("R8 in still off", in_clk_en, 0);
    chk("R8 core still off", core_clk_en, 0);
    chk("R6 cke low resume", cke, 0);
    tick();
    chk("R8 in on", in_clk_en, 1);
    chk("R8 core off", core_clk_en, 0);
    tick();
    chk("R8 core on", core_clk_en, 1);
    chk("R6 cke idle again", cke, 1);
    chk("R8 ddr on", ddr_clk_en, 1);
    chk("R7 other bits kept", cfg_q, 8'hA4);
  endtask

  initial begin
    t_reset();
    t_cfg_cke();
    t_entry();
    t_resume();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule